// File: doc/BRIEF.md
# Swap-Block Partial Write Sequencer

This block orders the flash operations for a logical write that updates only part of a NAND erase block. Flash cells can only be programmed from 1 to 0, and a bit can return to 1 only when its whole block is erased. A partial update therefore never writes over the original block. The sequencer first obtains a free swap block from an allocator. It copies into the swap block each original page that lies before the first written page. It then programs the new pages, and after them copies each original page that lies beyond the last written page. Finally it asks for the logical-to-physical mapping to point at the swap block.

A request supplies the first and last page of the write, the logical block number and the physical block that currently backs it. The sequencer sends one command at a time to a flash command engine, either a page copy (original to swap) or a page program (into swap). It waits for the engine's response before it moves to the next page. If any step reports failure, the swap block is flagged as bad and the mapping is left as it was. Erasing the released block and error correction are handled elsewhere.

Top module: `swap_write_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `allocReq`, `cmdValid`, `remapValid`, `markBadValid` and `doneValid` are all low.
- R2: A request with `startPage` or `endPage` not below PAGES, or with `startPage` greater than `endPage`, makes no allocation request and issues no command or remap. It ends with a `doneValid` pulse carrying `doneStatus` 1.
- R3: For a valid request, `allocReq` stays high until `allocGrant`, and no command is issued before the grant. Every command carries the original block on `cmdSrcBlock` and the granted swap block on `cmdDstBlock`.
- R4: When `startPage` is above 0, pages 0 to `startPage`-1 are copied (`cmdProgram` = 0). When `startPage` is 0, no page before the write is copied.
- R5: Pages `startPage` to `endPage` are each issued as a program command (`cmdProgram` = 1).
- R6: When `endPage` is below PAGES-1, pages `endPage`+1 to PAGES-1 are copied. When `endPage` is PAGES-1, no page after the write is copied.
- R7: Commands go out in strictly ascending page order, one per page of the block, so a fully successful request issues exactly PAGES commands.
- R8: A command is held with a stable page and kind until `cmdReady`. No further command is issued until `rspValid` answers the accepted one.
- R9: On success, one `remapValid` pulse carries the logical block and the swap block. It is followed on the next cycle by `doneValid` with `doneStatus` 0.
- R10: A response with `rspFail` high, on a copy or a program step, stops the sequence. No further command and no remap follow. One `markBadValid` pulse names the swap block, and the next cycle gives `doneValid` with `doneStatus` 2.
- R11: `startValid` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Request pulse, taken only when idle |
| startPage | input | PAGE_W+1 | First page of the write |
| endPage | input | PAGE_W+1 | Last page of the write |
| logBlock | input | BLK_W | Logical block being written |
| origBlock | input | BLK_W | Physical block currently mapped |
| busy | output | 1 | A request is in progress |
| allocReq | output | 1 | Request for a free swap block |
| allocGrant | input | 1 | Allocator supplies a block this cycle |
| allocBlock | input | BLK_W | Granted swap block |
| cmdValid | output | 1 | Command offered to the engine |
| cmdReady | input | 1 | Engine accepts the command |
| cmdProgram | output | 1 | 1 = program new data, 0 = copy original page |
| cmdPage | output | PAGE_W | Page index within the block |
| cmdSrcBlock | output | BLK_W | Source block of a copy |
| cmdDstBlock | output | BLK_W | Destination (swap) block |
| rspValid | input | 1 | Engine finished the accepted command |
| rspFail | input | 1 | That command failed |
| remapValid | output | 1 | Mapping update pulse |
| remapLogBlock | output | BLK_W | Logical block to remap |
| remapPhysBlock | output | BLK_W | New physical block (swap) |
| markBadValid | output | 1 | Bad-block report pulse |
| markBadBlock | output | BLK_W | Block to flag as bad |
| doneValid | output | 1 | Request finished |
| doneStatus | output | 2 | 0 ok, 1 index error, 2 step failure |

## Verification
The bench builds the sequencer with eight pages per block and six-bit block numbers. With a whole block only eight commands long, each run can be compared page by page against a list worked out from the start and end pages. The last page, single-page writes at either edge and full-block writes all stay cheap. The page inputs are four bits wide, so index 8 and above can be presented, which reaches the out-of-range path. Ready, response and grant latencies are varied per scenario to exercise command holding and the wait before allocation.

// File: rtl/swap_write_pkg.sv
package swap_write_pkg;
  typedef enum logic [1:0] {PH_HEAD = 2'd0, PH_PROG = 2'd1, PH_TAIL = 2'd2} phase_e;
  typedef enum logic [1:0] {ST_OK = 2'd0, ST_RANGE = 2'd1, ST_FAIL = 2'd2} status_e;

  typedef struct packed {
    logic capture;
    logic takeSwap;
    logic step;
    logic setRange;
    logic setFail;
  } strobe_t;
endpackage

// File: rtl/swap_write_dp.sv
module swap_write_dp
  import swap_write_pkg::*;
#(
  parameter int PAGES = 64,
  parameter int BLK_W = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      stb,
  input  logic [$clog2(PAGES):0]       startPage,
  input  logic [$clog2(PAGES):0]       endPage,
  input  logic [BLK_W-1:0]             logBlock,
  input  logic [BLK_W-1:0]             origBlock,
  input  logic [BLK_W-1:0]             allocBlock,
  output logic                         rangeBad,
  output logic                         allDone,
  output logic                         isProg,
  output logic [$clog2(PAGES)-1:0]     pageCnt,
  output logic [BLK_W-1:0]             srcBlk,
  output logic [BLK_W-1:0]             swapBlk,
  output logic [BLK_W-1:0]             logBlk,
  output logic [1:0]                   status
);
  localparam int PAGE_W = $clog2(PAGES);
  localparam int IDX_W  = PAGE_W + 1;
  localparam logic [PAGE_W-1:0] LAST = PAGE_W'(PAGES - 1);

  logic [PAGE_W-1:0] startR, endR;
  phase_e phase;
  logic phaseDone;

  assign rangeBad = (startPage >= IDX_W'(PAGES)) || (endPage >= IDX_W'(PAGES)) ||
                    (startPage > endPage);

  always_comb begin
    unique case (phase)
      PH_HEAD: phaseDone = (pageCnt == PAGE_W'(startR - 1'b1));
      PH_PROG: phaseDone = (pageCnt == endR);
      default: phaseDone = (pageCnt == LAST);
    endcase
  end

  assign allDone = phaseDone && ((phase == PH_TAIL) || (phase == PH_PROG && endR == LAST));
  assign isProg  = (phase == PH_PROG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startR  <= '0;
      endR    <= '0;
      pageCnt <= '0;
      phase   <= PH_HEAD;
      srcBlk  <= '0;
      swapBlk <= '0;
      logBlk  <= '0;
      status  <= ST_OK;
    end else begin
      if (stb.capture) begin
        startR <= startPage[PAGE_W-1:0];
        endR   <= endPage[PAGE_W-1:0];
        srcBlk <= origBlock;
        logBlk <= logBlock;
        status <= ST_OK;
      end
      if (stb.takeSwap) begin
        swapBlk <= allocBlock;
        pageCnt <= '0;
        phase   <= (startR != '0) ? PH_HEAD : PH_PROG;
      end
      if (stb.step) begin
        if (!phaseDone) begin
          pageCnt <= pageCnt + 1'b1;
        end else if (phase == PH_HEAD) begin
          phase   <= PH_PROG;
          pageCnt <= startR;
        end else begin
          phase   <= PH_TAIL;
          pageCnt <= endR + 1'b1;
        end
      end
      if (stb.setRange) status <= ST_RANGE;
      if (stb.setFail)  status <= ST_FAIL;
    end
  end
endmodule

// File: rtl/swap_write_ctrl.sv
module swap_write_ctrl
  import swap_write_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startValid,
  input  logic    rangeBad,
  input  logic    allocGrant,
  input  logic    cmdReady,
  input  logic    rspValid,
  input  logic    rspFail,
  input  logic    allDone,
  output strobe_t stb,
  output logic    busy,
  output logic    allocReq,
  output logic    cmdValid,
  output logic    remapValid,
  output logic    markBadValid,
  output logic    doneValid
);
  typedef enum logic [2:0] {
    S_IDLE, S_ALLOC, S_ISSUE, S_WAIT, S_REMAP, S_BAD, S_DONE
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt          = state;
    stb          = '0;
    allocReq     = 1'b0;
    cmdValid     = 1'b0;
    remapValid   = 1'b0;
    markBadValid = 1'b0;
    doneValid    = 1'b0;
    unique case (state)
      S_IDLE: if (startValid) begin
        stb.capture = 1'b1;
        if (rangeBad) begin
          stb.setRange = 1'b1;
          nxt = S_DONE;
        end else begin
          nxt = S_ALLOC;
        end
      end
      S_ALLOC: begin
        allocReq = 1'b1;
        if (allocGrant) begin
          stb.takeSwap = 1'b1;
          nxt = S_ISSUE;
        end
      end
      S_ISSUE: begin
        cmdValid = 1'b1;
        if (cmdReady) nxt = S_WAIT;
      end
      S_WAIT: if (rspValid) begin
        if (rspFail) nxt = S_BAD;
        else if (allDone) nxt = S_REMAP;
        else begin
          stb.step = 1'b1;
          nxt = S_ISSUE;
        end
      end
      S_REMAP: begin
        remapValid = 1'b1;
        nxt = S_DONE;
      end
      S_BAD: begin
        markBadValid = 1'b1;
        stb.setFail  = 1'b1;
        nxt = S_DONE;
      end
      default: begin
        doneValid = 1'b1;
        nxt = S_IDLE;
      end
    endcase
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/swap_write_seq.sv
module swap_write_seq
  import swap_write_pkg::*;
#(
  parameter int PAGES = 64,
  parameter int BLK_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startValid,
  input  logic [$clog2(PAGES):0]   startPage,
  input  logic [$clog2(PAGES):0]   endPage,
  input  logic [BLK_W-1:0]         logBlock,
  input  logic [BLK_W-1:0]         origBlock,
  output logic                     busy,
  output logic                     allocReq,
  input  logic                     allocGrant,
  input  logic [BLK_W-1:0]         allocBlock,
  output logic                     cmdValid,
  input  logic                     cmdReady,
  output logic                     cmdProgram,
  output logic [$clog2(PAGES)-1:0] cmdPage,
  output logic [BLK_W-1:0]         cmdSrcBlock,
  output logic [BLK_W-1:0]         cmdDstBlock,
  input  logic                     rspValid,
  input  logic                     rspFail,
  output logic                     remapValid,
  output logic [BLK_W-1:0]         remapLogBlock,
  output logic [BLK_W-1:0]         remapPhysBlock,
  output logic                     markBadValid,
  output logic [BLK_W-1:0]         markBadBlock,
  output logic                     doneValid,
  output logic [1:0]               doneStatus
);
  strobe_t stb;
  logic rangeBad, allDone, isProg;
  logic [BLK_W-1:0] swapBlk, srcBlk, logBlk;
  logic [1:0] status;

  swap_write_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .rangeBad(rangeBad),
    .allocGrant(allocGrant), .cmdReady(cmdReady), .rspValid(rspValid),
    .rspFail(rspFail), .allDone(allDone), .stb(stb), .busy(busy),
    .allocReq(allocReq), .cmdValid(cmdValid), .remapValid(remapValid),
    .markBadValid(markBadValid), .doneValid(doneValid)
  );

  swap_write_dp #(.PAGES(PAGES), .BLK_W(BLK_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .startPage(startPage), .endPage(endPage),
    .logBlock(logBlock), .origBlock(origBlock), .allocBlock(allocBlock),
    .rangeBad(rangeBad), .allDone(allDone), .isProg(isProg), .pageCnt(cmdPage),
    .srcBlk(srcBlk), .swapBlk(swapBlk), .logBlk(logBlk), .status(status)
  );

  assign cmdProgram     = isProg;
  assign cmdSrcBlock    = srcBlk;
  assign cmdDstBlock    = swapBlk;
  assign remapLogBlock  = logBlk;
  assign remapPhysBlock = swapBlk;
  assign markBadBlock   = swapBlk;
  assign doneStatus     = status;
endmodule

// File: rtl/swap_write_chk.sv
module swap_write_chk #(
  parameter int PAGES = 64,
  parameter int BLK_W = 10
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     startValid,
  input logic [$clog2(PAGES):0]   startPage,
  input logic [$clog2(PAGES):0]   endPage,
  input logic                     busy,
  input logic                     allocReq,
  input logic                     allocGrant,
  input logic                     cmdValid,
  input logic                     cmdReady,
  input logic                     cmdProgram,
  input logic [$clog2(PAGES)-1:0] cmdPage,
  input logic                     rspValid,
  input logic                     remapValid,
  input logic                     markBadValid,
  input logic                     doneValid,
  input logic [1:0]               doneStatus
);
  localparam int PAGE_W = $clog2(PAGES);
  localparam int IDX_W  = PAGE_W + 1;

  logic [IDX_W-1:0] sL, eL;
  logic [PAGE_W-1:0] prevPage;
  logic havePrev, outstanding, badReq;

  assign badReq = (startPage >= IDX_W'(PAGES)) || (endPage >= IDX_W'(PAGES)) ||
                  (startPage > endPage);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sL <= '0; eL <= '0; prevPage <= '0; havePrev <= 1'b0; outstanding <= 1'b0;
    end else begin
      if (startValid && !busy) begin
        sL <= startPage; eL <= endPage;
      end
      if (cmdValid && cmdReady) begin
        prevPage <= cmdPage; havePrev <= 1'b1; outstanding <= 1'b1;
      end else if (rspValid) begin
        outstanding <= 1'b0;
      end
      if (doneValid) havePrev <= 1'b0;
    end
  end

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdPage) && $stable(cmdProgram));
  // R8
  cmd_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !outstanding);
  // R7
  asc_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && havePrev |-> cmdPage > prevPage);
  // R5
  op_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cmdProgram == (({1'b0, cmdPage} >= sL) && ({1'b0, cmdPage} <= eL)));
  // R9
  remap_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    remapValid |=> doneValid && doneStatus == 2'd0);
  // R10
  bad_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    markBadValid |=> doneValid && doneStatus == 2'd2 && !remapValid);
  // R2
  range_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    startValid && !busy && badReq |=> doneValid && doneStatus == 2'd1 && !allocReq);
  // R3
  alloc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocReq && !allocGrant |=> allocReq && !cmdValid);
endmodule

bind swap_write_seq swap_write_chk #(.PAGES(PAGES), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .startPage(startPage),
  .endPage(endPage), .busy(busy), .allocReq(allocReq), .allocGrant(allocGrant),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdProgram(cmdProgram),
  .cmdPage(cmdPage), .rspValid(rspValid), .remapValid(remapValid),
  .markBadValid(markBadValid), .doneValid(doneValid), .doneStatus(doneStatus)
);

// File: tb/tb_swap_write_seq.sv
`timescale 1ns/1ps
module tb_swap_write_seq;
  localparam int PG = 8;
  localparam int BW = 6;
  localparam int PW = $clog2(PG);
  localparam logic [BW-1:0] SWAP = 6'd45;
  localparam logic [BW-1:0] ORIG = 6'd12;
  localparam logic [BW-1:0] LOGB = 6'd33;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic [PW:0] startPage = '0, endPage = '0;
  logic busy, allocReq, cmdValid, cmdProgram, remapValid, markBadValid, doneValid;
  logic allocGrant = 1'b0, cmdReady = 1'b0, rspValid = 1'b0, rspFail = 1'b0;
  logic [PW-1:0] cmdPage;
  logic [BW-1:0] cmdSrcBlock, cmdDstBlock, remapLogBlock, remapPhysBlock, markBadBlock;
  logic [1:0] doneStatus;

  swap_write_seq #(.PAGES(PG), .BLK_W(BW)) dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startPage(startPage),
    .endPage(endPage), .logBlock(LOGB), .origBlock(ORIG), .busy(busy),
    .allocReq(allocReq), .allocGrant(allocGrant), .allocBlock(SWAP),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdProgram(cmdProgram),
    .cmdPage(cmdPage), .cmdSrcBlock(cmdSrcBlock), .cmdDstBlock(cmdDstBlock),
    .rspValid(rspValid), .rspFail(rspFail), .remapValid(remapValid),
    .remapLogBlock(remapLogBlock), .remapPhysBlock(remapPhysBlock),
    .markBadValid(markBadValid), .markBadBlock(markBadBlock),
    .doneValid(doneValid), .doneStatus(doneStatus)
  );

  always #5 clk = ~clk;

  int nTests = 0, nFail = 0;
  int readyDly = 0, rspDly = 0, allocDly = 0, failIdx = -1;
  int logOp[0:31], logPage[0:31], logSrc[0:31], logDst[0:31];
  int nCmd = 0, waitCnt = 0, rspCnt = 0, allocCnt = 0, grants = 0, preGrant = 0;
  int holdErr = 0, holdPage = 0, nRemap = 0, nBad = 0, nDone = 0;
  int remapL = 0, remapP = 0, badBlk = 0, doneSt = -1;
  bit engBusy = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cmdReady = 1'b0; rspValid = 1'b0; rspFail = 1'b0; allocGrant = 1'b0;
    if (rstN) begin
      if (engBusy) begin
        if (rspCnt == 0) begin
          rspValid = 1'b1;
          rspFail  = (nCmd - 1 == failIdx);
          engBusy  = 1'b0;
        end else rspCnt--;
      end else if (cmdValid) begin
        if (grants == 0) preGrant++;
        if (waitCnt == 0) holdPage = int'(cmdPage);
        else if (int'(cmdPage) != holdPage) holdErr++;
        if (waitCnt >= readyDly) begin
          cmdReady = 1'b1;
          if (nCmd < 32) begin
            logOp[nCmd] = int'(cmdProgram); logPage[nCmd] = int'(cmdPage);
            logSrc[nCmd] = int'(cmdSrcBlock); logDst[nCmd] = int'(cmdDstBlock);
          end
          nCmd++; engBusy = 1'b1; rspCnt = rspDly; waitCnt = 0;
        end else waitCnt++;
      end
      if (allocReq) begin
        if (allocCnt >= allocDly) begin
          allocGrant = 1'b1; allocCnt = 0; grants++;
        end else allocCnt++;
      end
      if (remapValid) begin nRemap++; remapL = int'(remapLogBlock); remapP = int'(remapPhysBlock); end
      if (markBadValid) begin nBad++; badBlk = int'(markBadBlock); end
      if (doneValid) begin nDone++; doneSt = int'(doneStatus); end
    end
  end

  task automatic clearLogs();
    nCmd = 0; waitCnt = 0; allocCnt = 0; grants = 0; preGrant = 0; holdErr = 0;
    nRemap = 0; nBad = 0; nDone = 0; doneSt = -1; engBusy = 1'b0;
  endtask

  task automatic launch(input int s, input int e, input bit poke);
    int cyc = 0;
    clearLogs();
    @(negedge clk); #1;
    startPage = (PW+1)'(s); endPage = (PW+1)'(e); startValid = 1'b1;
    @(negedge clk); #1;
    startValid = 1'b0;
    while (nDone == 0 && cyc < 3000) begin
      @(negedge clk); #1;
      cyc++;
      // R11: a second request while busy must be ignored
      if (poke && cyc == 6) begin startPage = '0; endPage = '0; startValid = 1'b1; end
      else startValid = 1'b0;
    end
    startValid = 1'b0;
    chk(nDone == 1, "R9 done pulse seen", nDone, 1);
  endtask

  task automatic runWrite(input int s, input int e, input int f, input int rdy,
                          input int rsp, input int alc, input bit poke);
    int expN;
    readyDly = rdy; rspDly = rsp; allocDly = alc; failIdx = f;
    launch(s, e, poke);
    expN = (f < 0) ? PG : f + 1;
    chk(nCmd == expN, "R7 command count", nCmd, expN);
    chk(grants == 1 && preGrant == 0, "R3 grant before commands", preGrant, 0);
    chk(holdErr == 0, "R8 page held until ready", holdErr, 0);
    for (int k = 0; k < nCmd && k < 32; k++) begin
      bit expProg = (k >= s) && (k <= e);
      chk(logPage[k] == k, "R7 ascending page", logPage[k], k);
      if (k < s)       chk(logOp[k] == 0, "R4 head copy kind", logOp[k], 0);
      else if (k > e)  chk(logOp[k] == 0, "R6 tail copy kind", logOp[k], 0);
      else             chk(logOp[k] == int'(expProg), "R5 program kind", logOp[k], 1);
      chk(logSrc[k] == int'(ORIG) && logDst[k] == int'(SWAP), "R3 src/dst blocks",
          logDst[k], int'(SWAP));
    end
    if (f < 0) begin
      chk(nRemap == 1 && remapL == int'(LOGB), "R9 remap logical", remapL, int'(LOGB));
      chk(remapP == int'(SWAP), "R9 remap physical", remapP, int'(SWAP));
      chk(nBad == 0, "R9 no bad mark", nBad, 0);
      chk(doneSt == 0, "R9 status ok", doneSt, 0);
    end else begin
      chk(nBad == 1 && badBlk == int'(SWAP), "R10 bad block", badBlk, int'(SWAP));
      chk(nRemap == 0, "R10 no remap", nRemap, 0);
      chk(doneSt == 2, "R10 status fail", doneSt, 2);
    end
  endtask

  task automatic runBad(input int s, input int e);
    readyDly = 0; rspDly = 0; allocDly = 0; failIdx = -1;
    launch(s, e, 1'b0);
    chk(grants == 0 && nCmd == 0, "R2 no alloc or command", nCmd + grants, 0);
    chk(nRemap == 0 && nBad == 0, "R2 no remap", nRemap, 0);
    chk(doneSt == 1, "R2 status range", doneSt, 1);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !allocReq && !cmdValid, "R1 idle after reset", int'(busy), 0);
    chk(!remapValid && !markBadValid && !doneValid, "R1 no pulses", int'(doneValid), 0);
  endtask

  initial begin
    #1_000_000;
    nTests++; nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    testReset();
    runWrite(0, 7, -1, 0, 0, 0, 1'b0);   // R4 R6: full block, no copies
    runWrite(2, 5, -1, 2, 1, 3, 1'b0);   // R4 R5 R6: both edges copied
    runWrite(0, 3, -1, 0, 2, 0, 1'b0);   // R6 tail only
    runWrite(5, 7, -1, 1, 0, 1, 1'b0);   // R4 head only
    runWrite(7, 7, -1, 0, 0, 0, 1'b0);   // R4 last page alone
    runWrite(0, 0, -1, 3, 3, 2, 1'b0);   // R6 first page alone, slow engine
    runWrite(3, 4, -1, 1, 1, 0, 1'b1);   // R11 start ignored while busy
    runWrite(2, 5, 3, 0, 0, 0, 1'b0);    // R10 program step fails
    runWrite(3, 6, 0, 1, 1, 0, 1'b0);    // R10 head copy fails
    runBad(8, 8);                        // R2 index out of range
    runBad(5, 2);                        // R2 start after end
    runWrite(1, 6, -1, 0, 0, 0, 1'b0);   // R9 recovery after error
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule